// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models the status outputs a NOR-style flash device shows while an internal program or erase algorithm runs. A command decoder outside the block pulses `cmd_accept` at the end of the last write pulse of a command sequence. It also supplies the operation kind, whether the target is protected and, for unprotected targets, how many clock cycles the algorithm takes. While an operation is in progress, the block pulls the shared ready/busy line low. It also replaces read data with a status word whose lanes 6 and 14 carry a toggle bit, and that bit inverts once at the end of every read cycle.

An operation aimed at a protected target does not change the array. It only shows busy and toggles for a fixed window, and that window is given in nanoseconds and converted to clock cycles from the clock frequency parameter. An erase can be suspended and resumed. While it is suspended, one program operation may run, and the erase then continues with the cycles it had left. Reads outside any operation pass the array data straight through.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `rdy_pull_low` is 0, `status_word` equals `array_data`, and the toggle bit is 0.
- R2: A `cmd_accept` taken while idle makes `rdy_pull_low` 1 from the next cycle. For an unprotected target it stays 1 for exactly `cmd_len` cycles, with a length of 0 treated as 1.
- R3: While not idle, `status_word` carries the toggle bit on bits 6 and 14 and 0 on every other bit. A read cycle ends on the first clock where `ce_n` or `oe_n` is sampled high after both were sampled low. Each read cycle that ends while busy inverts the toggle bit.
- R4: When an operation completes, `rdy_pull_low` returns to 0 and `status_word` follows `array_data` again. Reads then leave the toggle bit unchanged.
- R5: A program aimed at a protected target holds busy for ceil(`PROG_PROT_NS`·`CLK_MHZ`/1000) cycles. With the defaults this is 100 cycles.
- R6: An erase whose targets are all protected holds busy for ceil(`ERASE_PROT_NS`·`CLK_MHZ`/1000) cycles. With the defaults this is 10000 cycles.
- R7: `suspend_req` during an erase releases `rdy_pull_low` from the next cycle and freezes the remaining count. Read cycles then leave the toggle bit unchanged.
- R8: While suspended, a program `cmd_accept` (`cmd_is_erase`=0) makes the block busy for that program's length and toggling again. When the program ends, the block returns to suspended.
- R9: `resume_req` while suspended resumes the erase. The total number of busy erase cycles equals the original length.
- R10: A `cmd_accept` while busy has no effect, and so does an erase `cmd_accept` while suspended.
- R11: A read cycle that ends in the final busy cycle still inverts the toggle bit. A `suspend_req` sampled on the completing cycle loses to completion, and the block goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_accept | input | 1 | Command-sequence complete strobe |
| cmd_is_erase | input | 1 | 1 = erase, 0 = program |
| cmd_protected | input | 1 | Target is protected |
| cmd_len | input | LEN_W | Algorithm length in cycles (unprotected) |
| suspend_req | input | 1 | Erase suspend request |
| resume_req | input | 1 | Erase resume request |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| array_data | input | 16 | Array read data |
| rdy_pull_low | output | 1 | Drive the open-drain ready/busy line low |
| status_word | output | 16 | Read data or status word |

## Verification
Two events can meet in one cycle. The first is the end of a read cycle and the completion of the operation. The bench provokes this by releasing `oe_n` so that the read ends exactly on the completing edge. It then judges the toggle bit at the start of the next operation, which must show the inverted value. The second is a suspend request on the completing edge, which must leave the block idle and showing array data rather than suspended. A behavioural model in the bench predicts both outputs on every clock, and the bench compares them with the block.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_SUSP  = 3'd3,
    ST_SPROG = 3'd4
  } op_state_t;

  // nanoseconds to cycles, rounded up
  function automatic longint ns_to_cycles(input longint ns, input longint mhz);
    return (ns * mhz + 64'sd999) / 64'sd1000;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // status word: toggle bit mirrored on lanes 6 and 14, rest zero
  function automatic logic [15:0] status_of(input logic tgl);
    logic [15:0] w;
    w     = '0;
    w[6]  = tgl;
    w[14] = tgl;
    return w;
  endfunction

endpackage

// File: rtl/fsg_read_end.sv
module fsg_read_end (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  output logic read_end
);
  logic rd_now, rd_q;

  assign rd_now = ~ce_n & ~oe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_now;
  end

  assign read_end = rd_q & ~rd_now;
endmodule

// File: rtl/fsg_op_timer.sv
module fsg_op_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic         done
);
  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= (load_val == '0) ? W'(1) : load_val;
    else if (run && cnt != '0)   cnt <= cnt - W'(1);
  end

  assign done = run && (cnt == W'(1));
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic tgl
);
  always_ff @(posedge clk) begin
    if (!rst_n)    tgl <= 1'b0;
    else if (flip) tgl <= ~tgl;
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int CLK_MHZ       = 100,
  parameter int PROG_PROT_NS  = 1000,
  parameter int ERASE_PROT_NS = 100000,
  parameter int LEN_W         = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_accept,
  input  logic             cmd_is_erase,
  input  logic             cmd_protected,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             suspend_req,
  input  logic             resume_req,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic [15:0]      array_data,
  output logic             rdy_pull_low,
  output logic [15:0]      status_word
);
  localparam int PROG_CYC  = int'(ns_to_cycles(longint'(PROG_PROT_NS), longint'(CLK_MHZ)));
  localparam int ERASE_CYC = int'(ns_to_cycles(longint'(ERASE_PROT_NS), longint'(CLK_MHZ)));
  localparam int CNT_W     = max_int(LEN_W, $clog2(max_int(PROG_CYC, ERASE_CYC) + 1));

  op_state_t        st, st_nx;
  logic             read_end, busy, tgl;
  logic             cmd_take_idle, cmd_take_susp;
  logic             main_run, main_done, sus_run, sus_done;
  logic [CNT_W-1:0] main_cnt, sus_cnt, len_ext, main_val, sus_val;

  assign len_ext       = CNT_W'(cmd_len);
  assign cmd_take_idle = (st == ST_IDLE) && cmd_accept;
  assign cmd_take_susp = (st == ST_SUSP) && cmd_accept && !cmd_is_erase && !resume_req;
  assign main_run      = (st == ST_PROG) || (st == ST_ERASE);
  assign sus_run       = (st == ST_SPROG);
  assign busy          = main_run || sus_run;

  always_comb begin
    if (!cmd_protected)   main_val = len_ext;
    else if (cmd_is_erase) main_val = CNT_W'(ERASE_CYC);
    else                   main_val = CNT_W'(PROG_CYC);
    sus_val = cmd_protected ? CNT_W'(PROG_CYC) : len_ext;
  end

  fsg_read_end u_rd (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .read_end(read_end)
  );

  fsg_op_timer #(.W(CNT_W)) u_main_tmr (
    .clk(clk), .rst_n(rst_n), .load(cmd_take_idle), .load_val(main_val),
    .run(main_run), .cnt(main_cnt), .done(main_done)
  );

  fsg_op_timer #(.W(CNT_W)) u_sus_tmr (
    .clk(clk), .rst_n(rst_n), .load(cmd_take_susp), .load_val(sus_val),
    .run(sus_run), .cnt(sus_cnt), .done(sus_done)
  );

  fsg_toggle u_tgl (
    .clk(clk), .rst_n(rst_n), .flip(busy && read_end), .tgl(tgl)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (cmd_accept) st_nx = cmd_is_erase ? ST_ERASE : ST_PROG;
      ST_PROG:  if (main_done) st_nx = ST_IDLE;
      ST_ERASE: begin
        if (main_done)        st_nx = ST_IDLE;
        else if (suspend_req) st_nx = ST_SUSP;
      end
      ST_SUSP: begin
        if (resume_req)         st_nx = ST_ERASE;
        else if (cmd_take_susp) st_nx = ST_SPROG;
      end
      ST_SPROG: if (sus_done) st_nx = ST_SUSP;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign rdy_pull_low = busy;
  assign status_word  = (st == ST_IDLE) ? array_data : status_of(tgl);
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk
  import flash_status_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input op_state_t        st,
  input logic             busy,
  input logic             tgl,
  input logic             read_end,
  input logic             main_done,
  input logic [CNT_W-1:0] main_cnt,
  input logic             cmd_accept,
  input logic             cmd_is_erase,
  input logic             resume_req,
  input logic             rdy_pull_low
);
  assert_busy_needs_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_pull_low) |-> $past(cmd_accept || resume_req));

  assert_read_flips_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && read_end) |=> (tgl != $past(tgl)));

  assert_done_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    main_done |=> !rdy_pull_low);

  assert_suspend_frozen_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP && read_end) |=> $stable(tgl));

  assert_suspend_program_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP && cmd_accept && !cmd_is_erase && !resume_req) |=> rdy_pull_low);

  assert_suspend_holds_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP && !resume_req) |=> $stable(main_cnt));

  assert_strobe_ignored_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG && cmd_accept && !main_done) |=> (st == ST_PROG));
endmodule

bind flash_status_gen flash_status_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .busy(busy), .tgl(tgl),
  .read_end(read_end), .main_done(main_done), .main_cnt(main_cnt),
  .cmd_accept(cmd_accept), .cmd_is_erase(cmd_is_erase),
  .resume_req(resume_req), .rdy_pull_low(rdy_pull_low)
);

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_accept = 1'b0, cmd_is_erase = 1'b0, cmd_protected = 1'b0;
  logic [15:0] cmd_len = '0;
  logic        suspend_req = 1'b0, resume_req = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1;
  logic [15:0] array_data = 16'hA5C3;
  logic        rdy_pull_low;
  logic [15:0] status_word;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  flash_status_gen u_flash_status_gen (.*);

  // behavioural reference: 0 idle, 1 program, 2 erase, 3 suspended, 4 program in suspend
  int m_mode = 0, m_rem = 0, m_srem = 0;
  bit m_tgl = 0, m_prev_rd = 0;

  always @(posedge clk) begin
    bit rd_now, rend, was_busy;
    int len;
    if (!rst_n) begin
      m_mode = 0; m_rem = 0; m_srem = 0; m_tgl = 0; m_prev_rd = 0;
    end else begin
      rd_now   = !ce_n && !oe_n;
      rend     = m_prev_rd && !rd_now;
      was_busy = (m_mode == 1) || (m_mode == 2) || (m_mode == 4);
      len      = (cmd_len == 0) ? 1 : int'(cmd_len);
      if (was_busy && rend) m_tgl = !m_tgl;
      case (m_mode)
        0: if (cmd_accept) begin
             m_mode = cmd_is_erase ? 2 : 1;
             m_rem  = cmd_protected ? (cmd_is_erase ? 10000 : 100) : len;
           end
        1: if (m_rem == 1) m_mode = 0; else m_rem--;
        2: if (m_rem == 1) m_mode = 0;
           else begin m_rem--; if (suspend_req) m_mode = 3; end
        3: if (resume_req) m_mode = 2;
           else if (cmd_accept && !cmd_is_erase) begin
             m_mode = 4; m_srem = cmd_protected ? 100 : len;
           end
        4: if (m_srem == 1) m_mode = 3; else m_srem--;
        default: m_mode = 0;
      endcase
      m_prev_rd = rd_now;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit e_rdy;
    logic [15:0] e_sw;
    if (rst_n) begin
      e_rdy = (m_mode == 1) || (m_mode == 2) || (m_mode == 4);
      e_sw  = (m_mode == 0) ? array_data : ((16'(m_tgl) << 6) | (16'(m_tgl) << 14));
      check(rdy_pull_low == e_rdy, {cur_tag, " ready/busy"}, int'(rdy_pull_low), int'(e_rdy));
      check(status_word == e_sw, {cur_tag, " status"}, int'(status_word), int'(e_sw));
    end
  end

  task automatic issue(input bit erase, input bit prot, input int len);
    @(negedge clk); #1;
    cmd_accept = 1; cmd_is_erase = erase; cmd_protected = prot; cmd_len = 16'(len);
    @(negedge clk); #1;
    cmd_accept = 0;
  endtask

  task automatic do_read();
    @(negedge clk); #1; ce_n = 0; oe_n = 0;
    @(negedge clk); #1; oe_n = 1; ce_n = 1;
    @(negedge clk); #1;
  endtask

  task automatic pulse_suspend();
    @(negedge clk); #1; suspend_req = 1;
    @(negedge clk); #1; suspend_req = 0;
  endtask

  task automatic pulse_resume();
    @(negedge clk); #1; resume_req = 1;
    @(negedge clk); #1; resume_req = 0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (rdy_pull_low) begin n++; @(negedge clk); end
  endtask

  task automatic wait_idle();
    while (rdy_pull_low) @(negedge clk);
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    bit b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(rdy_pull_low == 0, "R1 ready/busy after reset", int'(rdy_pull_low), 0);
    check(status_word == array_data, "R1 status after reset", int'(status_word), int'(array_data));

    // R2 busy length, R3 toggle on reads
    cur_tag = "R2";
    issue(0, 0, 5); measure(n);
    check(n == 5, "R2 program busy cycles", n, 5);
    cur_tag = "R3";
    issue(0, 0, 40);
    check(status_word[6] == 0 && status_word[14] == 0, "R3 toggle start", int'(status_word), 0);
    b0 = status_word[6];
    do_read();
    check(status_word[6] == !b0 && status_word[14] == !b0, "R3 first read flip", int'(status_word[6]), int'(!b0));
    do_read(); do_read();
    check(status_word == 16'h4040, "R3 three reads lanes 6/14", int'(status_word), 16'h4040);
    // R4 after completion
    cur_tag = "R4";
    wait_idle();
    array_data = 16'h1234;
    do_read();
    check(status_word == 16'h1234, "R4 array data after done", int'(status_word), 16'h1234);
    issue(0, 0, 3);
    check(status_word == 16'h4040, "R4 idle reads left toggle", int'(status_word), 16'h4040);
    wait_idle();

    // R2 zero length
    cur_tag = "R2";
    issue(1, 0, 0); measure(n);
    check(n == 1, "R2 zero length", n, 1);

    // R5, R6 protected windows
    cur_tag = "R5";
    issue(0, 1, 7); measure(n);
    check(n == 100, "R5 protected program window", n, 100);
    cur_tag = "R6";
    issue(1, 1, 7); measure(n);
    check(n == 10000, "R6 protected erase window", n, 10000);

    // R7 suspend, R8 program in suspend, R9 resume
    cur_tag = "R7";
    issue(1, 0, 30);
    repeat (4) @(negedge clk);
    pulse_suspend();
    check(rdy_pull_low == 0, "R7 suspend releases", int'(rdy_pull_low), 0);
    b0 = status_word[6];
    do_read();
    check(status_word[6] == b0, "R7 toggle frozen", int'(status_word[6]), int'(b0));
    cur_tag = "R10";
    issue(1, 0, 9);
    check(rdy_pull_low == 0, "R10 erase ignored in suspend", int'(rdy_pull_low), 0);
    cur_tag = "R8";
    issue(0, 0, 12);
    check(rdy_pull_low == 1, "R8 program in suspend busy", int'(rdy_pull_low), 1);
    b0 = status_word[6];
    do_read();
    check(status_word[6] == !b0, "R8 toggles again", int'(status_word[6]), int'(!b0));
    wait_idle();
    check(status_word[6] == !b0 && rdy_pull_low == 0, "R8 back to suspended", int'(status_word), int'(!b0) * 16'h4040);
    cur_tag = "R9";
    pulse_resume();
    check(rdy_pull_low == 1, "R9 resume busy", int'(rdy_pull_low), 1);
    wait_idle();

    // R10 strobe while busy
    cur_tag = "R10";
    issue(0, 0, 8);
    issue(1, 1, 3);
    measure(n);
    check(n == 6, "R10 strobe ignored while busy", n, 6);

    // R11 read end on the final busy edge
    cur_tag = "R11";
    issue(0, 0, 4);
    b0 = status_word[6];
    @(negedge clk);
    @(negedge clk); #1; ce_n = 0; oe_n = 0;
    @(negedge clk); #1; oe_n = 1; ce_n = 1;
    wait_idle();
    issue(0, 0, 2);
    check(status_word[6] == !b0, "R11 last-cycle read flips", int'(status_word[6]), int'(!b0));
    wait_idle();
    // R11 suspend on completing edge
    issue(1, 0, 3);
    @(negedge clk);
    @(negedge clk); #1; suspend_req = 1;
    @(negedge clk); #1; suspend_req = 0;
    @(negedge clk);
    check(rdy_pull_low == 0 && status_word == array_data, "R11 completion beats suspend",
          int'(status_word), int'(array_data));
    pulse_resume();
    check(rdy_pull_low == 0, "R11 resume after idle ignored", int'(rdy_pull_low), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule